// File: doc/BRIEF.md
# MDIO Management Master with Command Gateway

This block lets software talk to Ethernet PHYs over the two-wire management bus. It is programmed through two 32-bit registers on a small register bus. One is a command gateway holding data, register address, PHY address, opcode and a busy flag. The other is a configuration word holding the management clock period and two sample offsets. Software writes a command with busy set, and the block runs one Clause 22 frame. It generates MDC from the core clock, shifts the frame out on MDIO and releases the line for read data. For reads it captures the PHY's 16 bits into the gateway, then clears busy.

A finished transaction leaves the gateway locked until software writes all zeros. That zero write also stops any frame still running. MDC idles low and MDIO is released between frames. Each MDC period is split into core-clock ticks. The block drives a new MDIO bit at the output offset tick and samples MDIO at the input offset tick.

Top module: `mdio_gateway`

## Requirements
- R1: After reset both registers read as zero, MDC is low and the MDIO output enable is low.
- R2: Register reads return data on `reg_rdata` with `reg_rvalid` high one cycle after the request. Offset 0x0 is the gateway and offset 0x4 is the configuration word, and both read back what was stored. Every other offset reads zero.
- R3: While a frame runs, MDC is low for H core clocks and then high for H core clocks, where H = period code + 1. The period code sits in configuration bits 15:8. MDC stays low outside frames.
- R4: A gateway write with busy (bit 30) set starts a frame of 64 bits, sent MSB first. The frame is 32 ones, then 01, then the opcode (gateway bits 27:26; 01 write, 10 read), then the PHY address (bits 25:21), then the register address (bits 20:16). For a write it continues with turnaround 10 and the data (bits 15:0), and MDIO is driven for all 64 bits.
- R5: In a read frame, MDIO is driven for the first 46 bits and released from the turnaround through the last data bit.
- R6: When a read completes, gateway bits 15:0 hold the 16 bits captured from the PHY, MSB first. All other gateway fields are unchanged and busy is clear.
- R7: When a frame completes, busy clears and the gateway becomes locked. Any non-zero gateway write while busy or locked is ignored.
- R8: An all-zero gateway write clears the gateway and the lock at any time. If a frame is running, MDC returns low and MDIO is released on the next cycle, and the frame never completes.
- R9: A new MDIO output value becomes visible out+1 core clocks after the MDC falling edge that opens its bit period. Here out is the output offset in configuration bits 31:24.
- R10: Read data is sampled in the core-clock cycle where the count within the MDC period equals the input offset. The input offset sits in configuration bits 23:16.
- R11: An input or output offset larger than 2H-1 acts as offset 0.
- R12: A non-zero gateway write with busy clear, while idle and unlocked, is stored as written but starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench's PHY responder puts the correct read bit on MDIO only in the one cycle that matches the input offset, and drives the inverse in every other cycle. A design sampling a cycle early or late therefore returns the complemented data. Offsets past the period are tried so that a design that fails to fold them to zero hangs or captures garbage. The drive timing is measured at the preamble-to-start transition, which catches an off-by-one in the strobe pipeline. Non-zero writes are sent during a busy frame and after completion, and an abort is sent mid-frame. A design with a leaky lock would either overwrite the gateway or launch a stray frame, and one with a weak abort would keep toggling MDC or later report completion.

// File: rtl/mgw_pkg.sv
package mgw_pkg;

    localparam int REG_W     = 32;
    localparam int CODE_W    = 8;
    localparam int CNT_W     = CODE_W + 1;
    localparam int FRAME_LEN = 64;
    localparam int PRE_LEN   = 32;
    localparam int TA_POS    = 46;
    localparam int DAT_POS   = 48;
    localparam int RD_W      = 16;

    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_RD = 2'b10;

    typedef struct packed {
        logic        spare_hi;
        logic        busy;
        logic        spare_mid;
        logic        st;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } gw_t;

    typedef struct packed {
        logic [7:0] out_off;
        logic [7:0] in_off;
        logic [7:0] period;
        logic [2:0] spare_b;
        logic       full_drive;
        logic       spare_a;
        logic       io_3v3;
        logic [1:0] mode;
    } cfg_t;

    function automatic logic [FRAME_LEN-1:0] build_frame(input gw_t c);
        logic [1:0] ta;
        ta = (c.op == OP_RD) ? 2'b11 : 2'b10;
        return {{PRE_LEN{1'b1}}, 2'b01, c.op, c.phy, c.regad, ta, c.data};
    endfunction

endpackage

// File: rtl/mgw_mdc_gen.sv
module mgw_mdc_gen
    import mgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [CODE_W-1:0] period_code,
    input  logic [CODE_W-1:0] in_off,
    input  logic [CODE_W-1:0] out_off,
    output logic              mdc,
    output logic              drive_stb,
    output logic              sample_stb,
    output logic              period_end
);

    logic [CNT_W-1:0] cnt, top_q, half_q, in_q, out_q;
    logic [CNT_W-1:0] top_n, in_ext, out_ext;

    always_comb begin
        top_n   = {period_code, 1'b1};
        in_ext  = {1'b0, in_off};
        out_ext = {1'b0, out_off};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            top_q  <= '0;
            half_q <= '0;
            in_q   <= '0;
            out_q  <= '0;
        end else if (!active) begin
            cnt    <= '0;
            top_q  <= top_n;
            half_q <= {1'b0, period_code} + CNT_W'(1);
            in_q   <= (in_ext > top_n) ? '0 : in_ext;
            out_q  <= (out_ext > top_n) ? '0 : out_ext;
        end else begin
            cnt <= (cnt == top_q) ? '0 : cnt + CNT_W'(1);
        end
    end

    always_comb begin
        mdc        = active && (cnt >= half_q);
        drive_stb  = active && (cnt == out_q);
        sample_stb = active && (cnt == in_q);
        period_end = active && (cnt == top_q);
    end

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= top_q));

    assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> ($stable(top_q) && $stable(in_q) && $stable(out_q)));

endmodule

// File: rtl/mgw_framer.sv
module mgw_framer
    import mgw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            abort,
    input  gw_t             cmd,
    input  logic            drive_stb,
    input  logic            sample_stb,
    input  logic            period_end,
    input  logic            mdio_i,
    output logic            active,
    output logic            mdio_o,
    output logic            mdio_oe,
    output logic            done,
    output logic [RD_W-1:0] rd_data
);

    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DAT_POS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic [IDX_W-1:0]     idx;
    logic [FRAME_LEN-1:0] frame_sh;
    logic                 is_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            idx      <= '0;
            frame_sh <= '0;
            is_rd    <= 1'b0;
            mdio_o   <= 1'b0;
            mdio_oe  <= 1'b0;
            done     <= 1'b0;
            rd_data  <= '0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                active  <= 1'b0;
                mdio_oe <= 1'b0;
                mdio_o  <= 1'b0;
            end else if (start) begin
                active   <= 1'b1;
                idx      <= '0;
                frame_sh <= build_frame(cmd);
                is_rd    <= (cmd.op == OP_RD);
                rd_data  <= '0;
            end else if (active) begin
                if (drive_stb) begin
                    mdio_o   <= frame_sh[FRAME_LEN-1];
                    frame_sh <= {frame_sh[FRAME_LEN-2:0], 1'b0};
                    mdio_oe  <= !(is_rd && (idx >= TA_IDX));
                end
                if (sample_stb && is_rd && (idx >= DAT_IDX))
                    rd_data <= {rd_data[RD_W-2:0], mdio_i};
                if (period_end) begin
                    if (idx == LAST_IDX) begin
                        active  <= 1'b0;
                        done    <= 1'b1;
                        mdio_oe <= 1'b0;
                        mdio_o  <= 1'b0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
            end
        end
    end

    assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!active && !mdio_oe));

    assert_read_release_R5: assert property (@(posedge clk) disable iff (rst)
        (active && is_rd && (idx > TA_IDX)) |-> !mdio_oe);

endmodule

// File: rtl/mdio_gateway.sv
module mdio_gateway
    import mgw_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              reg_rvalid,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    localparam logic [ADDR_W-1:0] GW_OFF  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CFG_OFF = ADDR_W'(4);

    gw_t  gw_q;
    cfg_t cfg_q;
    logic locked_q;

    logic wr_gw, wr_cfg, wr_zero, start, abort;
    logic fr_active, fr_done;
    logic [RD_W-1:0] fr_rd;
    logic drive_stb, sample_stb, period_end;

    always_comb begin
        wr_gw   = reg_valid && reg_write && (reg_addr == GW_OFF);
        wr_cfg  = reg_valid && reg_write && (reg_addr == CFG_OFF);
        wr_zero = (reg_wdata == '0);
        abort   = wr_gw && wr_zero;
        start   = wr_gw && !wr_zero && !gw_q.busy && !locked_q && reg_wdata[30];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gw_q       <= '0;
            cfg_q      <= '0;
            locked_q   <= 1'b0;
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_valid && !reg_write;
            if (reg_valid && !reg_write) begin
                if (reg_addr == GW_OFF)       reg_rdata <= gw_q;
                else if (reg_addr == CFG_OFF) reg_rdata <= cfg_q;
                else                          reg_rdata <= '0;
            end
            if (fr_done) begin
                gw_q.busy <= 1'b0;
                locked_q  <= 1'b1;
                if (gw_q.op == OP_RD) gw_q.data <= fr_rd;
            end
            if (wr_gw) begin
                if (wr_zero) begin
                    gw_q     <= '0;
                    locked_q <= 1'b0;
                end else if (!gw_q.busy && !locked_q) begin
                    gw_q <= gw_t'(reg_wdata);
                end
            end
            if (wr_cfg) cfg_q <= cfg_t'(reg_wdata);
        end
    end

    mgw_mdc_gen u_mdc_gen (
        .clk         (clk),
        .rst         (rst),
        .active      (fr_active),
        .period_code (cfg_q.period),
        .in_off      (cfg_q.in_off),
        .out_off     (cfg_q.out_off),
        .mdc         (mdc),
        .drive_stb   (drive_stb),
        .sample_stb  (sample_stb),
        .period_end  (period_end)
    );

    mgw_framer u_framer (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .abort       (abort),
        .cmd         (gw_t'(reg_wdata)),
        .drive_stb   (drive_stb),
        .sample_stb  (sample_stb),
        .period_end  (period_end),
        .mdio_i      (mdio_i),
        .active      (fr_active),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .done        (fr_done),
        .rd_data     (fr_rd)
    );

    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_gw && !wr_zero && (gw_q.busy || locked_q) && !fr_done) |=> (gw_q == $past(gw_q)));

    assert_busy_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (fr_done && !abort) |=> (!gw_q.busy && locked_q));

    assert_start_runs_R4: assert property (@(posedge clk) disable iff (rst)
        start |=> fr_active);

    assert_idle_mdc_R3: assert property (@(posedge clk) disable iff (rst)
        !gw_q.busy |-> !fr_active || fr_done || !mdc || $past(gw_q.busy));

endmodule

// File: tb/test_mdio_gateway.sv
module test_mdio_gateway;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_valid = 1'b0;
    logic        reg_write = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mdio_gateway #(.ADDR_W(4)) i_mdio_gateway (
        .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct {
        logic [63:0] bits;
        logic [63:0] oe;
        string       tag;
    } frame_exp_t;
    frame_exp_t exp_q[$];

    bit          mon_en = 1'b0;
    int          mon_cnt = 0;
    int          total_rises = 0;
    logic [63:0] cap = '0;
    logic [63:0] cap_oe = '0;

    always begin
        @(posedge mdc);
        #1;
        total_rises++;
        if (mon_en) begin
            cap    = {cap[62:0], mdio_o};
            cap_oe = {cap_oe[62:0], mdio_oe};
            mon_cnt++;
            if (mon_cnt == 64) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected frame", cap, '0);
                end else begin
                    frame_exp_t e;
                    e = exp_q.pop_front();
                    check((cap & e.oe) == (e.bits & e.oe), e.tag, cap, e.bits);
                    check(cap_oe == e.oe, "R5 output enable pattern", cap_oe, e.oe);
                end
                mon_cnt = 0;
            end
        end
    end

    // PHY responder: correct bit only in the cycle matching the input offset
    int          phy_k = 0;
    int          phy_c = 0;
    int          phy_in = 0;
    logic [15:0] phy_resp = '0;
    logic        prev_mdc = 1'b0;

    always @(posedge clk) begin
        #1;
        if (prev_mdc && !mdc) begin
            phy_k = phy_k + 1;
            phy_c = 0;
        end else begin
            phy_c = phy_c + 1;
        end
        prev_mdc = mdc;
        if (phy_k >= 48 && phy_k <= 63)
            mdio_i = (phy_c == phy_in) ? phy_resp[63-phy_k] : ~phy_resp[63-phy_k];
        else
            mdio_i = 1'b1;
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        check(reg_rvalid === 1'b1, "R2 rvalid one cycle after read", {63'd0, reg_rvalid}, 64'd1);
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_cmd(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] dat);
        return {1'b0, 1'b1, 1'b0, 1'b1, op, phy, ra, dat};
    endfunction

    task automatic launch(input logic [31:0] cmd, input logic [15:0] resp, input bit monitored);
        frame_exp_t e;
        logic [1:0] ta;
        ta     = (cmd[27:26] == 2'b10) ? 2'b11 : 2'b10;
        e.bits = {{32{1'b1}}, 2'b01, cmd[27:26], cmd[25:21], cmd[20:16], ta, cmd[15:0]};
        e.oe   = (cmd[27:26] == 2'b10) ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
        e.tag  = (cmd[27:26] == 2'b10) ? "R4 read frame header" : "R4 write frame bits";
        phy_resp = resp;
        phy_k    = 0;
        mon_cnt  = 0;
        mon_en   = monitored;
        if (monitored) exp_q.push_back(e);
        bus_write(4'h0, cmd);
    endtask

    task automatic wait_idle(output logic [31:0] v);
        v = 32'hFFFF_FFFF;
        for (int i = 0; i < 20000; i++) begin
            bus_read(4'h0, v);
            if (!v[30]) break;
        end
    endtask

    // Call right after launch: measures drive offset and half periods
    task automatic measure(input int exp_drive, input int exp_half);
        int n;
        repeat (32) @(negedge mdc);
        n = 0;
        while (mdio_o !== 1'b0 && n < 1000) begin @(posedge clk); #1; n++; end
        check(n == exp_drive, "R9 drive offset after MDC fall", n, exp_drive);
        @(posedge mdc);
        n = 0;
        while (mdc === 1'b1 && n < 1000) begin @(posedge clk); #1; n++; end
        check(n == exp_half, "R3 MDC high time", n, exp_half);
        n = 0;
        while (mdc === 1'b0 && n < 1000) begin @(posedge clk); #1; n++; end
        check(n == exp_half, "R3 MDC low time", n, exp_half);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cmd;
        int r0;

        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check(mdc === 1'b0, "R1 MDC low after reset", {63'd0, mdc}, 0);
        check(mdio_oe === 1'b0, "R1 output enable low after reset", {63'd0, mdio_oe}, 0);
        bus_read(4'h0, v); check(v == 0, "R1 gateway zero", v, 0);
        bus_read(4'h4, v); check(v == 0, "R1 config zero", v, 0);

        // R2 config readback and unmapped offset
        bus_write(4'h4, 32'h0D06_0F15);
        bus_read(4'h4, v); check(v == 32'h0D06_0F15, "R2 config readback", v, 32'h0D06_0F15);
        bus_write(4'h8, 32'hDEAD_BEEF);
        bus_read(4'h8, v); check(v == 0, "R2 unmapped offset reads zero", v, 0);

        // R12 store without start
        r0 = total_rises;
        bus_write(4'h0, 32'h0000_1234);
        repeat (200) @(posedge clk);
        check(total_rises == r0, "R12 no frame without busy", total_rises, r0);
        bus_read(4'h0, v); check(v == 32'h0000_1234, "R12 stored value", v, 32'h1234);
        bus_write(4'h0, 32'h0);

        // Write frame, typical timing (H=16, in 6, out 13)
        phy_in = 6;
        cmd = mk_cmd(2'b01, 5'h11, 5'h0A, 16'hA5C3);
        launch(cmd, 16'h0, 1'b1);
        measure(14, 16);
        wait_idle(v);
        check(v == (cmd & ~32'h4000_0000), "R7 busy cleared after write", v, cmd & ~32'h4000_0000);
        // R7 locked: non-zero write ignored, no frame
        r0 = total_rises;
        bus_write(4'h0, mk_cmd(2'b10, 5'h01, 5'h01, 16'h0));
        repeat (300) @(posedge clk);
        bus_read(4'h0, v);
        check(v == (cmd & ~32'h4000_0000), "R7 locked gateway ignores write", v, cmd & ~32'h4000_0000);
        check(total_rises == r0, "R7 no frame while locked", total_rises, r0);
        bus_write(4'h0, 32'h0);
        bus_read(4'h0, v); check(v == 0, "R8 release clears gateway", v, 0);

        // Read frame, typical timing; write during busy ignored
        cmd = mk_cmd(2'b10, 5'h03, 5'h02, 16'h0000);
        launch(cmd, 16'h8E71, 1'b1);
        bus_write(4'h0, mk_cmd(2'b01, 5'h1F, 5'h1F, 16'hFFFF));
        bus_read(4'h0, v); check(v == cmd, "R7 write while busy ignored", v, cmd);
        wait_idle(v);
        check(v == {cmd[31:31], 1'b0, cmd[29:16], 16'h8E71}, "R6 R10 read data in gateway",
              v, {cmd[31:31], 1'b0, cmd[29:16], 16'h8E71});
        bus_write(4'h0, 32'h0);

        // Fast timing: H=4, in 5, out 2
        bus_write(4'h4, 32'h0205_0301);
        phy_in = 5;
        cmd = mk_cmd(2'b01, 5'h0C, 5'h15, 16'h5A0F);
        launch(cmd, 16'h0, 1'b1);
        measure(3, 4);
        wait_idle(v);
        check(v == (cmd & ~32'h4000_0000), "R4 fast write completes", v, cmd & ~32'h4000_0000);
        bus_write(4'h0, 32'h0);
        cmd = mk_cmd(2'b10, 5'h1E, 5'h07, 16'hFFFF);
        launch(cmd, 16'h1359, 1'b1);
        wait_idle(v);
        check(v[15:0] == 16'h1359, "R10 fast read sample offset", v[15:0], 16'h1359);
        check(v[31:16] == {1'b0, 1'b0, cmd[29:16]}, "R6 other fields kept", v[31:16], {2'b00, cmd[29:16]});
        bus_write(4'h0, 32'h0);

        // R11 offsets beyond the period act as 0 (H=2, top=3)
        bus_write(4'h4, 32'hC8FA_0100);
        phy_in = 0;
        cmd = mk_cmd(2'b10, 5'h05, 5'h11, 16'h0);
        launch(cmd, 16'h3C5A, 1'b1);
        measure(1, 2);
        wait_idle(v);
        check(v[15:0] == 16'h3C5A, "R11 clamped input offset", v[15:0], 16'h3C5A);
        bus_write(4'h0, 32'h0);

        // R8 abort mid-frame
        bus_write(4'h4, 32'h0D06_0F15);
        phy_in = 6;
        launch(mk_cmd(2'b01, 5'h02, 5'h03, 16'hBEEF), 16'h0, 1'b0);
        repeat (300) @(posedge clk);
        bus_write(4'h0, 32'h0);
        check(mdc === 1'b0, "R8 MDC low after abort", {63'd0, mdc}, 0);
        check(mdio_oe === 1'b0, "R8 MDIO released after abort", {63'd0, mdio_oe}, 0);
        r0 = total_rises;
        repeat (3000) @(posedge clk);
        check(total_rises == r0, "R8 no MDC after abort", total_rises, r0);
        bus_read(4'h0, v); check(v == 0, "R8 aborted frame never completes", v, 0);

        // New frame after abort
        cmd = mk_cmd(2'b10, 5'h09, 5'h04, 16'h0);
        launch(cmd, 16'hC0DE, 1'b1);
        wait_idle(v);
        check(v[15:0] == 16'hC0DE, "R8 frame after abort works", v[15:0], 16'hC0DE);
        bus_write(4'h0, 32'h0);

        repeat (10) @(posedge clk);
        check(exp_q.size() == 0, "R4 all frames observed", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule